// File: doc/BRIEF.md
# Inverted Page Table Linear Search Translator

This block turns a virtual address into a physical address by looking it up in one global table. The table has one slot for every physical frame, and all processes share it. A slot does not hold a frame number. It holds the process ID of the frame's owner, the virtual page number mapped into that frame, some info bits and a valid flag. The frame number is the slot index: the block compares the request with each slot in turn, starting at index zero, and the index of the first matching slot becomes the upper part of the physical address.

A requester presents a process ID and a virtual address under a valid/ready handshake. The block then stays busy while it checks one slot per cycle through the table's read port. It ends the lookup with a single-cycle done pulse, which carries either a physical address together with the slot's info bits, or a page-fault flag if no slot matched. A separate write port lets software fill slots or clear them. The block only signals a fault; it does no fault handling, caching or replacement.

Top module: `ipt_linear_xlate`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and every slot is invalid, so any lookup ends in a fault.
- R2: A slot matches only when its valid flag is set and both its process ID and its virtual page number equal the request's. The info bits take no part in the comparison.
- R3: On a hit, paddr is the matching slot index in bits [PA_W-1:OFF_W], with the request's low OFF_W address bits (default 12, for 4 KB pages) copied unchanged into bits [OFF_W-1:0].
- R4: When several slots match, the lowest index wins.
- R5: When no slot matches, done comes with fault = 1, paddr = 0 and info = 0, exactly FRAMES cycles after the accepting edge.
- R6: A hit in slot k raises done exactly k+1 cycles after the accepting edge. The accepting edge is the rising clock edge at which req_valid and req_ready are both 1.
- R7: req_ready is 0 from the accepting edge until done rises. done is high for exactly one cycle. req_ready is 1 in the done cycle.
- R8: On a hit, info carries the matching slot's info bits.
- R9: A write with wr_valid = 0 clears that slot's valid flag, so the slot no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_pid | input | PID_W | Process ID of the request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | No slot matched (valid when done) |
| paddr | output | IDX_W+OFF_W | Physical address (valid when done) |
| info | output | INFO_W | Info bits of the matching slot |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot (frame) index to write |
| wr_valid | input | 1 | Valid flag written into the slot |
| wr_pid | input | PID_W | Owner process ID written |
| wr_vpn | input | VPN_W | Virtual page number written |
| wr_info | input | INFO_W | Info bits written |

## Verification
A wrong scan index, or a counter that stops at the wrong place, shows up as a done that arrives a cycle early or late, or as a wrong frame field in paddr. Both are visible in the cycle done rises, because every lookup with a known hit slot has a latency the bench can predict exactly. A comparator that skips one field, or ignores the valid flag, returns a hit where a fault is expected; the duplicate-mapping and cleared-slot cases expose this within one lookup. A handshake state that is out of step shows up as req_ready held high while busy, or as a done pulse wider than one cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   typedef enum logic [0:0] {
      SCAN_IDLE = 1'b0,
      SCAN_BUSY = 1'b1
   } scan_state_e;
endpackage

// File: rtl/ipt_slot_store.sv
module ipt_slot_store #(
   parameter int DEPTH  = 16,
   parameter int PID_W  = 16,
   parameter int VPN_W  = 52,
   parameter int INFO_W = 12,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [INFO_W-1:0] wr_info,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [PID_W-1:0]  rd_pid,
   output logic [VPN_W-1:0]  rd_vpn,
   output logic [INFO_W-1:0] rd_info
);
   logic [PID_W-1:0]  pid_mem  [DEPTH];
   logic [VPN_W-1:0]  vpn_mem  [DEPTH];
   logic [INFO_W-1:0] info_mem [DEPTH];
   logic [DEPTH-1:0]  vld_q;

   // payload storage: no reset needed, guarded by the valid flags
   always_ff @(posedge clk) begin
      if (wr_en) begin
         pid_mem[wr_idx]  <= wr_pid;
         vpn_mem[wr_idx]  <= wr_vpn;
         info_mem[wr_idx] <= wr_info;
      end
   end

   // valid flags: one resettable flop per slot
   for (genvar s = 0; s < DEPTH; s++) begin : g_vld
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[s] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(s))) begin
            vld_q[s] <= wr_valid;
         end
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_pid   = pid_mem[rd_idx];
   assign rd_vpn   = vpn_mem[rd_idx];
   assign rd_info  = info_mem[rd_idx];
endmodule

// File: rtl/ipt_slot_cmp.sv
module ipt_slot_cmp #(
   parameter int PID_W = 16,
   parameter int VPN_W = 52
) (
   input  logic             slot_valid,
   input  logic [PID_W-1:0] slot_pid,
   input  logic [VPN_W-1:0] slot_vpn,
   input  logic [PID_W-1:0] key_pid,
   input  logic [VPN_W-1:0] key_vpn,
   output logic             hit
);
   logic pid_eq;
   logic vpn_eq;

   assign pid_eq = (slot_pid == key_pid);
   assign vpn_eq = (slot_vpn == key_vpn);
   assign hit    = slot_valid && pid_eq && vpn_eq;
endmodule

// File: rtl/ipt_scan_ctrl.sv
module ipt_scan_ctrl
   import ipt_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int PID_W  = 16,
   parameter int VPN_W  = 52,
   parameter int OFF_W  = 12,
   parameter int INFO_W = 12,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int VA_W  = VPN_W + OFF_W,
   localparam int PA_W  = IDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic [IDX_W-1:0]  scan_idx,
   output logic [PID_W-1:0]  key_pid,
   output logic [VPN_W-1:0]  key_vpn,
   input  logic              slot_hit,
   input  logic [INFO_W-1:0] slot_info,
   output logic              done,
   output logic              fault,
   output logic [PA_W-1:0]   paddr,
   output logic [INFO_W-1:0] info
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   scan_state_e       state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [PID_W-1:0]  pid_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [OFF_W-1:0]  off_q;
   logic              done_q;
   logic              fault_q;
   logic [PA_W-1:0]   paddr_q;
   logic [INFO_W-1:0] info_q;
   logic              accept;

   assign req_ready = (state_q == SCAN_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SCAN_IDLE;
         idx_q   <= '0;
         pid_q   <= '0;
         vpn_q   <= '0;
         off_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         paddr_q <= '0;
         info_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SCAN_IDLE: begin
               if (accept) begin
                  pid_q   <= req_pid;
                  vpn_q   <= req_vaddr[VA_W-1:OFF_W];
                  off_q   <= req_vaddr[OFF_W-1:0];
                  idx_q   <= '0;
                  state_q <= SCAN_BUSY;
               end
            end
            SCAN_BUSY: begin
               if (slot_hit) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b0;
                  paddr_q <= {idx_q, off_q};
                  info_q  <= slot_info;
                  state_q <= SCAN_IDLE;
               end else if (idx_q == LAST_IDX) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b1;
                  paddr_q <= '0;
                  info_q  <= '0;
                  state_q <= SCAN_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end

   assign scan_idx = idx_q;
   assign key_pid  = pid_q;
   assign key_vpn  = vpn_q;
   assign done     = done_q;
   assign fault    = fault_q;
   assign paddr    = paddr_q;
   assign info     = info_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R6
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(!req_ready) && req_ready));
   // R5
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (paddr == '0 && info == '0));
endmodule

// File: rtl/ipt_linear_xlate.sv
module ipt_linear_xlate #(
   parameter int FRAMES = 16,
   parameter int PID_W  = 16,
   parameter int VPN_W  = 52,
   parameter int INFO_W = 12,
   parameter int OFF_W  = 12,
   localparam int IDX_W = $clog2(FRAMES),
   localparam int VA_W  = VPN_W + OFF_W,
   localparam int PA_W  = IDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              done,
   output logic              fault,
   output logic [PA_W-1:0]   paddr,
   output logic [INFO_W-1:0] info,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [INFO_W-1:0] wr_info
);
   initial begin
      frames_pow2_chk: assert (FRAMES >= 2 && (1 << IDX_W) == FRAMES)
         else $error("FRAMES must be a power of two, at least 2");
      widths_chk: assert (PID_W > 0 && VPN_W > 0 && INFO_W > 0 && OFF_W > 0)
         else $error("field widths must be positive");
   end

   logic [IDX_W-1:0]  scan_idx;
   logic [PID_W-1:0]  key_pid;
   logic [VPN_W-1:0]  key_vpn;
   logic              slot_valid;
   logic [PID_W-1:0]  slot_pid;
   logic [VPN_W-1:0]  slot_vpn;
   logic [INFO_W-1:0] slot_info;
   logic              slot_hit;

   ipt_slot_store #(
      .DEPTH(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .INFO_W(INFO_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_valid (wr_valid),
      .wr_pid   (wr_pid),
      .wr_vpn   (wr_vpn),
      .wr_info  (wr_info),
      .rd_idx   (scan_idx),
      .rd_valid (slot_valid),
      .rd_pid   (slot_pid),
      .rd_vpn   (slot_vpn),
      .rd_info  (slot_info)
   );

   ipt_slot_cmp #(
      .PID_W(PID_W), .VPN_W(VPN_W)
   ) i_cmp (
      .slot_valid (slot_valid),
      .slot_pid   (slot_pid),
      .slot_vpn   (slot_vpn),
      .key_pid    (key_pid),
      .key_vpn    (key_vpn),
      .hit        (slot_hit)
   );

   ipt_scan_ctrl #(
      .DEPTH(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .INFO_W(INFO_W)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_pid   (req_pid),
      .req_vaddr (req_vaddr),
      .scan_idx  (scan_idx),
      .key_pid   (key_pid),
      .key_vpn   (key_vpn),
      .slot_hit  (slot_hit),
      .slot_info (slot_info),
      .done      (done),
      .fault     (fault),
      .paddr     (paddr),
      .info      (info)
   );

   // R2
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit |-> slot_valid);
endmodule

// File: tb/test_ipt_linear_xlate.sv
module test_ipt_linear_xlate;
   localparam int FRAMES = 16;
   localparam int PID_W  = 16;
   localparam int VPN_W  = 52;
   localparam int INFO_W = 12;
   localparam int OFF_W  = 12;
   localparam int IDX_W  = $clog2(FRAMES);
   localparam int VA_W   = VPN_W + OFF_W;
   localparam int PA_W   = IDX_W + OFF_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [PID_W-1:0]  req_pid = '0;
   logic [VA_W-1:0]   req_vaddr = '0;
   logic              done;
   logic              fault;
   logic [PA_W-1:0]   paddr;
   logic [INFO_W-1:0] info;
   logic              wr_en = 1'b0;
   logic [IDX_W-1:0]  wr_idx = '0;
   logic              wr_valid = 1'b0;
   logic [PID_W-1:0]  wr_pid = '0;
   logic [VPN_W-1:0]  wr_vpn = '0;
   logic [INFO_W-1:0] wr_info = '0;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   ipt_linear_xlate #(
      .FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .INFO_W(INFO_W), .OFF_W(OFF_W)
   ) i_ipt_linear_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_pid(req_pid), .req_vaddr(req_vaddr),
      .done(done), .fault(fault), .paddr(paddr), .info(info),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_info(wr_info)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_slot(input int idx, input logic v, input logic [PID_W-1:0] p,
                           input logic [VPN_W-1:0] vp, input logic [INFO_W-1:0] inf);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v;
      wr_pid = p; wr_vpn = vp; wr_info = inf;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one lookup: checks latency, result fields, handshake and pulse width
   task automatic lookup(input string req, input logic [PID_W-1:0] p,
                         input logic [VPN_W-1:0] vp, input logic [OFF_W-1:0] off,
                         input logic exp_fault, input int exp_idx,
                         input logic [INFO_W-1:0] exp_info);
      int lat;
      int exp_lat;
      logic ready_bad;
      logic [PA_W-1:0] exp_pa;
      @(negedge clk);
      req_valid = 1'b1; req_pid = p; req_vaddr = {vp, off};
      @(posedge clk);
      #1 req_valid = 1'b0;
      lat = 0;
      ready_bad = 1'b0;
      forever begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (done || lat > FRAMES + 2) break;
         if (req_ready) ready_bad = 1'b1;
      end
      exp_lat = exp_fault ? FRAMES : exp_idx + 1;
      exp_pa  = exp_fault ? '0 : {IDX_W'(exp_idx), off};
      check({req, " latency"}, 64'(lat), 64'(exp_lat));
      check({req, " fault"}, 64'(fault), 64'(exp_fault));
      check({req, " paddr"}, 64'(paddr), 64'(exp_pa));
      check({req, " info"}, 64'(info), 64'(exp_fault ? '0 : exp_info));
      check("R7 ready low while busy", 64'(ready_bad), 64'(0));
      check("R7 ready high in done cycle", 64'(req_ready), 64'(1));
      @(negedge clk);
      check("R7 done one cycle", 64'(done), 64'(0));
   endtask

   task automatic t_reset;
      check("R1 ready after reset", 64'(req_ready), 64'(1));
      check("R1 done after reset", 64'(done), 64'(0));
      lookup("R1 empty table", 16'h0000, 52'h0, 12'h000, 1'b1, 0, '0);
   endtask

   task automatic t_fill;
      put_slot(0,  1'b1, 16'h0001, 52'h00001,       12'h111);
      put_slot(3,  1'b1, 16'h0005, 52'h00123,       12'hABC);
      put_slot(7,  1'b1, 16'h0005, 52'h00456,       12'h777);
      put_slot(10, 1'b1, 16'h0009, 52'h00123,       12'h0A0);
      put_slot(12, 1'b1, 16'h0005, 52'h00456,       12'hCCC);
      put_slot(15, 1'b1, 16'hBEEF, 52'hF_FFFF_FFFF_FFFF, 12'hFFF);
   endtask

   task automatic t_hits;
      lookup("R3 R6 R8 hit slot 3", 16'h0005, 52'h00123, 12'hFED, 1'b0, 3, 12'hABC);
      lookup("R6 hit slot 0", 16'h0001, 52'h00001, 12'h001, 1'b0, 0, 12'h111);
      lookup("R6 hit last slot", 16'hBEEF, 52'hF_FFFF_FFFF_FFFF, 12'h800, 1'b0, 15, 12'hFFF);
   endtask

   task automatic t_pid_and_order;
      lookup("R2 pid selects slot 10", 16'h0009, 52'h00123, 12'h0F0, 1'b0, 10, 12'h0A0);
      lookup("R2 pid mismatch faults", 16'h0006, 52'h00123, 12'h0F0, 1'b1, 0, '0);
      lookup("R2 vpn mismatch faults", 16'h0005, 52'h00124, 12'h000, 1'b1, 0, '0);
      lookup("R4 lowest index wins", 16'h0005, 52'h00456, 12'h5A5, 1'b0, 7, 12'h777);
   endtask

   task automatic t_invalidate;
      put_slot(7, 1'b0, 16'h0005, 52'h00456, 12'h777);
      lookup("R9 R4 cleared slot skipped", 16'h0005, 52'h00456, 12'h321, 1'b0, 12, 12'hCCC);
      put_slot(3, 1'b0, 16'h0005, 52'h00123, 12'hABC);
      lookup("R9 R5 cleared slot faults", 16'h0005, 52'h00123, 12'h0, 1'b1, 0, '0);
      put_slot(3, 1'b1, 16'h0005, 52'h00123, 12'h246);
      lookup("R2 R8 info rewritten still hits", 16'h0005, 52'h00123, 12'h0AA, 1'b0, 3, 12'h246);
   endtask

   initial begin
      #800000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_hits();
      t_pid_and_order();
      t_invalidate();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule